// File: doc/BRIEF.md
# MDIO-Tunnelled 32-bit Register Bridge

The bridge sits behind an MDIO slave that has already decoded each clause-22 frame into a PHY address, a register number, a direction and a 16-bit data word. It maps these 16-bit accesses onto a 32-bit internal register bus. The bus has a byte address, write data, a write strobe, a read strobe and read data. The read data is returned combinationally in the cycle the read strobe is high.

The 32-bit word index is split into three parts:
- A page register supplies the upper bits. Software loads it through one fixed PHY/register pair.
- The low three bits of the PHY address supply the middle bits.
- The register number, less its lowest bit, supplies the bottom bits.

The lowest bit of the register number picks the half-word: even registers carry bits 15:0 and odd registers carry bits 31:16. The bridge makes each 32-bit transfer atomic:
- **Reads:** reading the low half performs the whole 32-bit bus read and keeps the upper half for the read of the odd register that follows.
- **Writes:** writing the high half only parks it in a holding register. The later write of the low half issues one combined 32-bit strobe.

Top module: `mdio32_bridge`

## Requirements
- R1: After reset the bus strobes and the response valid are low, and the page register is zero, so the first data access lands in page 0.
- R2: A data access to PHY address 0x10..0x17 uses byte address {page, PHY[2:0], REG[4:1], 2'b00}, which is 18 bits with a 9-bit page.
- R3: A read of an even register in the data window raises the bus read strobe for exactly one cycle, one cycle after the access. The response carries bus read data bits 15:0 one cycle after the strobe.
- R4: A read of an odd register in the data window issues no bus access. It returns bits 31:16 captured by the most recent even-register read, even if the bus contents have since changed.
- R5: A write to an odd register in the data window issues no bus strobe and stores the 16-bit value as the pending upper half.
- R6: A write to an even register in the data window raises the bus write strobe for one cycle, one cycle after the access, with write data {pending upper half, new low half}. The pending upper half survives for later low writes.
- R7: A write to PHY 0x1F register 0x10 loads the low 9 bits of the data into the page register and causes no bus strobe. A read there returns the page zero-extended to 16 bits.
- R8: Accesses to any other PHY address, or to PHY 0x1F with another register, cause no bus strobe. They leave the page, the pending upper half and the captured upper half unchanged, and reads there return 0xFFFF.
- R9: Every read access produces exactly one response, two cycles after the access; writes produce none. Back-to-back accesses on consecutive cycles are all honoured in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One-cycle pulse per decoded MDIO access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_phy | input | 5 | MDIO PHY address |
| acc_reg | input | 5 | MDIO register number |
| acc_wdata | input | 16 | Write data of the MDIO access |
| rsp_valid | output | 1 | Read response valid, one cycle |
| rsp_rdata | output | 16 | Read response data |
| bus_addr | output | 18 | Internal byte address |
| bus_wdata | output | 32 | Internal write data |
| bus_wr | output | 1 | Internal write strobe |
| bus_rd | output | 1 | Internal read strobe |
| bus_rdata | input | 32 | Internal read data, valid while bus_rd is high |

## Verification
The assertions rely on the following properties of the inputs:
- `acc_valid` is a single-cycle pulse whose fields are stable within that cycle.
- The register bus answers in the same cycle as `bus_rd`.
- The MDIO slave never has more than one access per cycle.

The stimulus keeps within these limits. It drives each access for one cycle on the falling edge. It models the bus as a pure function of the address plus a scramble word, and changes that word only while the bridge is idle. Sequences mix back-to-back and spaced accesses, page changes, orphan low writes, and accesses outside the decoded window interleaved between half-word pairs.

// File: rtl/mdio32_pkg.sv
package mdio32_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_RD_LO,
        K_RD_HI,
        K_WR_LO,
        K_WR_HI,
        K_PG_WR,
        K_PG_RD,
        K_VOID_RD
    } kind_e;

    typedef struct packed {
        logic        vld;
        kind_e       kind;
        logic [2:0]  phy_lo;
        logic [3:0]  word_lo;
        logic [15:0] wdata;
    } req_t;

endpackage

// File: rtl/mdio32_decode.sv
module mdio32_decode
    import mdio32_pkg::*;
#(
    parameter logic [4:0] DATA_PHY_BASE = 5'h10,
    parameter logic [4:0] PAGE_PHY      = 5'h1F,
    parameter logic [4:0] PAGE_REG      = 5'h10
) (
    input  logic        acc_valid,
    input  logic        acc_wr,
    input  logic [4:0]  acc_phy,
    input  logic [4:0]  acc_reg,
    input  logic [15:0] acc_wdata,
    output req_t        req
);
    localparam logic [1:0] DATA_TAG = DATA_PHY_BASE[4:3];

    logic in_data;
    logic in_page;

    always_comb begin
        in_data      = (acc_phy[4:3] == DATA_TAG);
        in_page      = (acc_phy == PAGE_PHY) && (acc_reg == PAGE_REG);
        req.vld      = acc_valid;
        req.phy_lo   = acc_phy[2:0];
        req.word_lo  = acc_reg[4:1];
        req.wdata    = acc_wdata;
        req.kind     = K_NONE;
        if (acc_valid) begin
            if (in_data) begin
                case ({acc_wr, acc_reg[0]})
                    2'b00:   req.kind = K_RD_LO;
                    2'b01:   req.kind = K_RD_HI;
                    2'b10:   req.kind = K_WR_LO;
                    default: req.kind = K_WR_HI;
                endcase
            end else if (in_page) begin
                req.kind = acc_wr ? K_PG_WR : K_PG_RD;
            end else begin
                req.kind = acc_wr ? K_NONE : K_VOID_RD;
            end
        end
    end

endmodule

// File: rtl/mdio32_latch.sv
module mdio32_latch
    import mdio32_pkg::*;
#(
    parameter int PAGE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  req_t              req,
    input  logic              stage_rd_lo,
    input  logic [15:0]       bus_rdata_hi,
    output logic [PAGE_W-1:0] page_q,
    output logic [15:0]       wr_hi_q,
    output logic [15:0]       rd_hi_q
);
    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [15:0]       wr_hi;
        logic [15:0]       rd_hi;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (req.vld && req.kind == K_PG_WR) begin
            hold_d.page = req.wdata[PAGE_W-1:0];
        end
        if (req.vld && req.kind == K_WR_HI) begin
            hold_d.wr_hi = req.wdata;
        end
        if (stage_rd_lo) begin
            hold_d.rd_hi = bus_rdata_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign page_q  = hold_q.page;
    assign wr_hi_q = hold_q.wr_hi;
    assign rd_hi_q = hold_q.rd_hi;

    // R5: a pending upper half changes only on an upper-half write
    a_r5_hold_only_on_hi: assert property (@(posedge clk) disable iff (!rst_n)
        !(req.vld && req.kind == K_WR_HI) |=> $stable(wr_hi_q));

endmodule

// File: rtl/mdio32_bridge.sv
module mdio32_bridge
    import mdio32_pkg::*;
#(
    parameter int         PAGE_W        = 9,
    parameter logic [4:0] DATA_PHY_BASE = 5'h10,
    parameter logic [4:0] PAGE_PHY      = 5'h1F,
    parameter logic [4:0] PAGE_REG      = 5'h10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_wr,
    input  logic [4:0]  acc_phy,
    input  logic [4:0]  acc_reg,
    input  logic [15:0] acc_wdata,
    output logic        rsp_valid,
    output logic [15:0] rsp_rdata,
    output logic [PAGE_W+8:0] bus_addr,
    output logic [31:0] bus_wdata,
    output logic        bus_wr,
    output logic        bus_rd,
    input  logic [31:0] bus_rdata
);
    localparam int ADDR_W = PAGE_W + 9;
    localparam int PAD_W  = 16 - PAGE_W;

    typedef struct packed {
        req_t              req;
        logic [ADDR_W-1:0] addr;
        logic              rsp_vld;
        logic [15:0]       rsp_data;
    } state_t;

    req_t              req;
    state_t            st_d, st_q;
    logic [PAGE_W-1:0] page_q;
    logic [15:0]       wr_hi_q;
    logic [15:0]       rd_hi_q;
    logic              stage_rd_lo;

    mdio32_decode #(
        .DATA_PHY_BASE(DATA_PHY_BASE),
        .PAGE_PHY     (PAGE_PHY),
        .PAGE_REG     (PAGE_REG)
    ) i_decode (
        .acc_valid(acc_valid),
        .acc_wr   (acc_wr),
        .acc_phy  (acc_phy),
        .acc_reg  (acc_reg),
        .acc_wdata(acc_wdata),
        .req      (req)
    );

    assign stage_rd_lo = st_q.req.vld && (st_q.req.kind == K_RD_LO);

    mdio32_latch #(
        .PAGE_W(PAGE_W)
    ) i_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .stage_rd_lo (stage_rd_lo),
        .bus_rdata_hi(bus_rdata[31:16]),
        .page_q      (page_q),
        .wr_hi_q     (wr_hi_q),
        .rd_hi_q     (rd_hi_q)
    );

    always_comb begin
        st_d          = st_q;
        st_d.req      = req;
        if (req.vld) begin
            st_d.addr = {page_q, req.phy_lo, req.word_lo, 2'b00};
        end
        st_d.rsp_vld  = 1'b0;
        st_d.rsp_data = st_q.rsp_data;
        if (st_q.req.vld) begin
            case (st_q.req.kind)
                K_RD_LO: begin
                    st_d.rsp_vld  = 1'b1;
                    st_d.rsp_data = bus_rdata[15:0];
                end
                K_RD_HI: begin
                    st_d.rsp_vld  = 1'b1;
                    st_d.rsp_data = rd_hi_q;
                end
                K_PG_RD: begin
                    st_d.rsp_vld  = 1'b1;
                    st_d.rsp_data = {{PAD_W{1'b0}}, page_q};
                end
                K_VOID_RD: begin
                    st_d.rsp_vld  = 1'b1;
                    st_d.rsp_data = 16'hFFFF;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_addr  = st_q.addr;
    assign bus_rd    = stage_rd_lo;
    assign bus_wr    = st_q.req.vld && (st_q.req.kind == K_WR_LO);
    assign bus_wdata = {wr_hi_q, st_q.req.wdata};
    assign rsp_valid = st_q.rsp_vld;
    assign rsp_rdata = st_q.rsp_data;

    // R3: even-register read in the data window strobes the bus next cycle
    a_r3_rd_after_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_wr && acc_phy[4:3] == DATA_PHY_BASE[4:3] && !acc_reg[0])
        |=> bus_rd);

    // R5: upper-half write never strobes the bus
    a_r5_no_wr_on_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_phy[4:3] == DATA_PHY_BASE[4:3] && acc_reg[0])
        |=> (!bus_wr && !bus_rd));

    // R6: even-register write strobes the bus once, next cycle
    a_r6_wr_after_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_wr && acc_phy[4:3] == DATA_PHY_BASE[4:3] && !acc_reg[0])
        |=> bus_wr);

    // R8: accesses outside the window never reach the bus
    a_r8_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_phy[4:3] != DATA_PHY_BASE[4:3]) |=> (!bus_wr && !bus_rd));

    // R9: a bus read is always answered one cycle later
    a_r9_rsp_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> rsp_valid);

    // R6: read and write strobes are never high together
    a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

endmodule

// File: tb/test_mdio32_bridge.sv
module test_mdio32_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_wr = 1'b0;
    logic [4:0]  acc_phy = '0;
    logic [4:0]  acc_reg = '0;
    logic [15:0] acc_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [17:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_wr;
    logic        bus_rd;
    logic [31:0] bus_rdata;
    logic [15:0] salt = 16'h5A3C;

    int checks = 0;
    int fails  = 0;

    logic [8:0]  page_m  = '0;
    logic [15:0] hold_m  = '0;
    logic [15:0] rdhi_m  = '0;

    logic [50:0] bus_q[$];
    string       bus_tag_q[$];
    logic [15:0] rsp_q[$];
    string       rsp_tag_q[$];

    always #5 clk = ~clk;

    function automatic logic [31:0] model(input logic [17:0] a, input logic [15:0] s);
        return {a[17:2] ^ s, ~a[17:2]};
    endfunction

    assign bus_rdata = model(bus_addr, salt);

    mdio32_bridge i_mdio32_bridge (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_valid(acc_valid),
        .acc_wr   (acc_wr),
        .acc_phy  (acc_phy),
        .acc_reg  (acc_reg),
        .acc_wdata(acc_wdata),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_rdata(bus_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: called at a falling edge, presents one access for one cycle
    task automatic access(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] d, input string tag);
        logic [17:0] a;
        logic [31:0] v;
        if (phy[4:3] == 2'b10) begin
            a = {page_m, phy[2:0], rg[4:1], 2'b00};
            if (wr && rg[0]) begin
                hold_m = d;
            end else if (wr) begin
                bus_q.push_back({1'b1, a, hold_m, d});
                bus_tag_q.push_back(tag);
            end else if (!rg[0]) begin
                v = model(a, salt);
                bus_q.push_back({1'b0, a, 32'h0});
                bus_tag_q.push_back(tag);
                rsp_q.push_back(v[15:0]);
                rsp_tag_q.push_back(tag);
                rdhi_m = v[31:16];
            end else begin
                rsp_q.push_back(rdhi_m);
                rsp_tag_q.push_back(tag);
            end
        end else if (phy == 5'h1F && rg == 5'h10) begin
            if (wr) begin
                page_m = d[8:0];
            end else begin
                rsp_q.push_back({7'b0, page_m});
                rsp_tag_q.push_back(tag);
            end
        end else if (!wr) begin
            rsp_q.push_back(16'hFFFF);
            rsp_tag_q.push_back(tag);
        end
        acc_valid = 1'b1;
        acc_wr    = wr;
        acc_phy   = phy;
        acc_reg   = rg;
        acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor: pops expected bus events and responses as they appear
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (bus_rd || bus_wr)) begin
                if (bus_q.size() == 0) begin
                    check(1'b0, "R8 unexpected bus strobe", {45'b0, bus_wr, bus_addr}, 64'h0);
                end else begin
                    logic [50:0] e;
                    string t;
                    e = bus_q.pop_front();
                    t = bus_tag_q.pop_front();
                    if (e[50]) begin
                        check(bus_wr && bus_addr == e[49:32] && bus_wdata == e[31:0], t,
                              {13'b0, bus_wr, bus_addr, bus_wdata}, {13'b0, e});
                    end else begin
                        check(bus_rd && bus_addr == e[49:32], t,
                              {45'b0, bus_wr, bus_addr}, {45'b0, e[50:32]});
                    end
                end
            end
            if (rst_n && rsp_valid) begin
                if (rsp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected response", {48'b0, rsp_rdata}, 64'h0);
                end else begin
                    logic [15:0] r;
                    string t;
                    r = rsp_q.pop_front();
                    t = rsp_tag_q.pop_front();
                    check(rsp_rdata == r, t, {48'b0, rsp_rdata}, {48'b0, r});
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        check(!bus_rd && !bus_wr && !rsp_valid, "R1 reset outputs",
              {61'b0, bus_rd, bus_wr, rsp_valid}, 64'h0);
        rst_n = 1'b1;
        idle(2);
        check(!bus_rd && !bus_wr && !rsp_valid, "R1 idle after reset",
              {61'b0, bus_rd, bus_wr, rsp_valid}, 64'h0);

        access(1'b0, 5'h10, 5'h00, 16'h0, "R1 R3 low read in page 0");
        access(1'b0, 5'h10, 5'h01, 16'h0, "R4 high read back-to-back");
        idle(3);
        salt = 16'h0F0F;
        idle(1);
        access(1'b0, 5'h10, 5'h01, 16'h0, "R4 high read after bus change");
        idle(2);

        access(1'b1, 5'h1F, 5'h10, 16'h01A5, "R7 page write");
        access(1'b0, 5'h1F, 5'h10, 16'h0, "R7 page read");
        access(1'b0, 5'h15, 5'h0E, 16'h0, "R2 low read paged");
        access(1'b0, 5'h15, 5'h0F, 16'h0, "R4 high read paged");
        idle(2);

        access(1'b1, 5'h13, 5'h05, 16'hBEEF, "R5 high write");
        idle(2);
        access(1'b1, 5'h13, 5'h04, 16'h1234, "R6 low write combined");
        access(1'b1, 5'h17, 5'h1E, 16'h4321, "R6 low write reuses held half");
        idle(2);

        access(1'b0, 5'h05, 5'h00, 16'h0, "R8 read outside window");
        access(1'b1, 5'h05, 5'h01, 16'hAAAA, "R8 write outside window");
        access(1'b1, 5'h1F, 5'h11, 16'h0077, "R8 write wrong page register");
        access(1'b0, 5'h1F, 5'h12, 16'h0, "R8 read wrong page register");
        access(1'b0, 5'h1F, 5'h10, 16'h0, "R8 page unchanged");
        access(1'b1, 5'h11, 5'h02, 16'h9999, "R8 held half unchanged");
        access(1'b0, 5'h11, 5'h03, 16'h0, "R8 captured half unchanged");
        idle(2);

        access(1'b1, 5'h1F, 5'h10, 16'hFE03, "R7 page keeps low 9 bits");
        access(1'b0, 5'h1F, 5'h10, 16'h0, "R7 page read truncated");
        access(1'b1, 5'h12, 5'h07, 16'h0C0D, "R5 high write new page");
        access(1'b1, 5'h12, 5'h06, 16'h0A0B, "R2 R6 write address in new page");
        idle(2);

        for (int i = 0; i < 24; i++) begin
            logic [4:0] p;
            logic [4:0] r;
            p = {2'b10, 3'(i * 3)};
            r = 5'((i * 7) & 5'h1E);
            case (i % 4)
                0: access(1'b1, p, r | 5'h01, 16'(i * 16'h1111), "R5 sweep high write");
                1: access(1'b1, p, r, 16'(i * 16'h0101), "R6 sweep low write");
                2: access(1'b0, p, r, 16'h0, "R9 sweep low read");
                default: access(1'b0, p, r | 5'h01, 16'h0, "R9 sweep high read");
            endcase
            if (i % 5 == 0) idle(1);
        end
        idle(5);

        check(bus_q.size() == 0, "R9 all bus events seen", 64'(bus_q.size()), 64'h0);
        check(rsp_q.size() == 0, "R9 all responses seen", 64'(rsp_q.size()), 64'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule